// File: doc/BRIEF.md
# Programmable-Increment Time-of-Day Counter

This block keeps a 64-bit time-of-day value for hardware timestamping. The value does not move by a fixed step each clock. A divider counts local clock cycles, and once every programmed tick period the counter adds a 24-bit addend. Software scales that addend with a left shift, so the low-order bits of the count hold fractions of a nanosecond. Two examples: a 25 MHz oscillator uses period 1 with addend 40<<18, and a 24 MHz oscillator uses period 3 with addend 125<<14. Because of this scaling, fewer bits count whole nanoseconds and the counter wraps far sooner than a plain nanosecond count would. At 25 MHz it wraps after roughly 19.5 hours. A sticky flag records each wrap.

Software uses a four-entry, 32-bit register window. A read of the low half copies the high half into a shadow register in the same cycle, and a later read of the high half returns that shadow. A write of the low half is held in a staging register. The following write of the high half loads the whole 64-bit value in one edge and restarts the tick divider. A new control word is taken up at the next tick boundary, so the running count is not disturbed. A tick period of zero stops the counter.

Top module: `systime_counter`

## Requirements
- R1: After reset the time is 0, the control word reads 0, the wrap flag is 0 and counting is stopped.
- R2: The control word (address 2) holds the tick period in bits 31:24 and the addend in bits 23:0. A read of address 2 returns the last word written. Any addend up to 0xFFFFFF is valid.
- R3: With period P>0 and addend A, the time rises by A once every P clock cycles and holds between those ticks. The first tick falls P edges after a load.
- R4: A tick period of 0 keeps the time constant.
- R5: A control word written while counting is taken up on the edge of the next tick, and that tick still uses the old addend. When counting is stopped, the word is taken up on the next edge. Neither case changes the count.
- R6: A read of address 0 returns time bits 31:0 and captures time bits 63:32 in the same cycle. A later read of address 1 returns the captured value, even if the counter has moved on since.
- R7: A write to address 0 only stages the value and leaves the time unchanged. A write to address 1 loads {written word, staged word} on that edge, and the tick divider restarts from zero.
- R8: The wrap flag (address 3, bit 0, also on `wrap_o`) is set on the edge where an addition carries out of bit 63. It stays set until a write to address 3 with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the address-0 capture) |
| reg_addr | input | 2 | 0 time low, 1 time high, 2 control word, 3 wrap flag |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| time_o | output | 64 | Current time value |
| wrap_o | output | 1 | Sticky wrap flag |

## Verification
A register write takes effect on the clock edge that samples it. Read data is valid during the strobe cycle itself. A tick appears on `time_o` exactly P edges after a load or after the previous tick. The wrap flag rises on the same edge as the carrying tick. A new control word takes effect on the next tick edge, or on the next edge while counting is stopped. The bench drives every access on a falling edge and samples read data one nanosecond later. It counts whole rising edges from the loading write before it samples `time_o` on the next falling edge. Each expected value therefore refers to one specific edge.

// File: rtl/systime_pkg.sv
package systime_pkg;
  typedef enum logic [1:0] {
    SEL_TLO = 2'd0,
    SEL_THI = 2'd1,
    SEL_CTL = 2'd2,
    SEL_FLG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/systime_tick.sv
// Tick divider: emits one step pulse every period_i cycles; period 0 stops it.
module systime_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  input  logic             restart_i,
  output logic             step_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] last_cnt;
  logic             run;

  always_comb begin
    run      = (period_i != '0);
    last_cnt = period_i - PER_W'(1);
    step_o   = run && (cnt_q == last_cnt);
    if (restart_i || step_o || !run) cnt_d = '0;
    else                             cnt_d = cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i != '0) |-> (cnt_q < period_i));
endmodule

// File: rtl/systime_ctl.sv
// Control word: last written word plus the word in force, swapped at a tick boundary.
module systime_ctl #(
  parameter int REG_W = 32,
  parameter int PER_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [REG_W-1:0]         wdata_i,
  input  logic                     step_i,
  output logic [REG_W-1:0]         word_o,
  output logic [PER_W-1:0]         period_o,
  output logic [REG_W-PER_W-1:0]   incr_o
);
  localparam int INC_W = REG_W - PER_W;

  logic [REG_W-1:0] pend_q, pend_d;
  logic             vld_q, vld_d;
  logic [REG_W-1:0] act_q, act_d;
  logic             stopped, adopt;

  always_comb begin
    stopped = (act_q[REG_W-1 -: PER_W] == '0);
    adopt   = vld_q && (step_i || stopped);
    pend_d  = wr_i ? wdata_i : pend_q;
    vld_d   = wr_i ? 1'b1 : (adopt ? 1'b0 : vld_q);
    act_d   = adopt ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
      act_q  <= act_d;
    end
  end

  assign word_o   = pend_q;
  assign period_o = act_q[REG_W-1 -: PER_W];
  assign incr_o   = act_q[INC_W-1:0];

  // R5
  no_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |=> $stable(act_q));
  // R5
  wait_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !stopped && !step_i) |=> $stable(act_q));
endmodule

// File: rtl/systime_accum.sv
// 64-bit accumulator: adds the addend on a step, loads on request, reports carry-out.
module systime_accum #(
  parameter int CNT_W = 64,
  parameter int INC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [INC_W-1:0] incr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] time_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] time_q, time_d;
  logic [CNT_W:0]   sum;
  logic             time_en;

  always_comb begin
    sum     = {1'b0, time_q} + {{(CNT_W+1-INC_W){1'b0}}, incr_i};
    time_en = load_i || step_i;
    time_d  = load_i ? load_val_i : sum[CNT_W-1:0];
    carry_o = step_i && !load_i && sum[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  assign time_o = time_q;

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(time_q));
  // R7
  atomic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (time_q == $past(load_val_i)));
endmodule

// File: rtl/systime_counter.sv
module systime_counter
  import systime_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int PER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [2*REG_W-1:0] time_o,
  output logic               wrap_o
);
  localparam int CNT_W = 2 * REG_W;
  localparam int INC_W = REG_W - PER_W;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  reg_sel_e         sel;
  logic             wr_lo, wr_hi, wr_ctl, wr_flg, rd_lo, flg_clr;
  logic [REG_W-1:0] stage_q, stage_d, shadow_q, shadow_d, ctl_word;
  logic             wrap_q, wrap_d;
  logic [PER_W-1:0] period;
  logic [INC_W-1:0] incr;
  logic             step, carry;
  logic [CNT_W-1:0] time_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    sel      = reg_sel_e'(reg_addr);
    wr_lo    = reg_wr && (sel == SEL_TLO);
    wr_hi    = reg_wr && (sel == SEL_THI);
    wr_ctl   = reg_wr && (sel == SEL_CTL);
    wr_flg   = reg_wr && (sel == SEL_FLG);
    rd_lo    = reg_rd && (sel == SEL_TLO);
    flg_clr  = wr_flg && reg_wdata[0];
    stage_d  = wr_lo ? reg_wdata : stage_q;
    shadow_d = rd_lo ? time_val[CNT_W-1 -: REG_W] : shadow_q;
    wrap_d   = carry ? 1'b1 : (flg_clr ? 1'b0 : wrap_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stage_q  <= '0;
      shadow_q <= '0;
      wrap_q   <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      shadow_q <= shadow_d;
      wrap_q   <= wrap_d;
    end
  end

  systime_ctl #(.REG_W(REG_W), .PER_W(PER_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (wr_ctl),
    .wdata_i  (reg_wdata),
    .step_i   (step),
    .word_o   (ctl_word),
    .period_o (period),
    .incr_o   (incr)
  );

  systime_tick #(.PER_W(PER_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .period_i  (period),
    .restart_i (wr_hi),
    .step_o    (step)
  );

  systime_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .step_i     (step),
    .incr_i     (incr),
    .load_i     (wr_hi),
    .load_val_i ({reg_wdata, stage_q}),
    .time_o     (time_val),
    .carry_o    (carry)
  );

  always_comb begin
    unique case (sel)
      SEL_TLO: reg_rdata = time_val[REG_W-1:0];
      SEL_THI: reg_rdata = shadow_q;
      SEL_CTL: reg_rdata = ctl_word;
      default: reg_rdata = {{(REG_W-1){1'b0}}, wrap_q};
    endcase
  end

  assign time_o = time_val;
  assign wrap_o = wrap_q;

  // R8
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wrap_q && !flg_clr) |=> wrap_q);
  // R8
  wrap_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    carry |=> wrap_q);
endmodule

// File: tb/tb_systime_counter.sv
module tb_systime_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [63:0] time_o;
  logic        wrap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  systime_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_o(time_o), .wrap_o(wrap_o)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [23:0] inc;
    logic [15:0] n;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd1,   24'hA00000, 16'd10,  64'h0000_0000_0640_0000},
    '{8'd3,   24'h1F4000, 16'd10,  64'h0000_0000_005D_C000},
    '{8'd2,   24'hFFFFFF, 16'd7,   64'h0000_0000_02FF_FFFD},
    '{8'd0,   24'h000005, 16'd10,  64'h0},
    '{8'd5,   24'h000001, 16'd4,   64'h0},
    '{8'd5,   24'h000001, 16'd5,   64'h1},
    '{8'd255, 24'h000007, 16'd600, 64'hE},
    '{8'd4,   24'h000003, 16'd13,  64'h9}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] hi_now;
    do_reset();
    // R1 reset state
    @(negedge clk);
    check("R1 time", time_o, 64'h0);
    check("R1 wrap", {63'h0, wrap_o}, 64'h0);
    rd(2'd2, d); check("R1 ctl", {32'h0, d}, 64'h0);
    rd(2'd3, d); check("R1 flag", {32'h0, d}, 64'h0);
    // R4 stopped after reset
    repeat (6) @(posedge clk);
    @(negedge clk) check("R4 idle", time_o, 64'h0);

    // R3 / R4 / R2 vector walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd2, {VECS[i].per, VECS[i].inc});
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      repeat (int'(VECS[i].n)) @(posedge clk);
      @(negedge clk);
      check(VECS[i].per == 8'd0 ? "R4 vector" : "R3 vector", time_o, VECS[i].exp);
    end

    // R2 read-back of control word
    do_reset();
    wr(2'd2, 32'h0312_3456);
    rd(2'd2, d); check("R2 readback", {32'h0, d}, 64'h0312_3456);

    // R7 staged low write
    do_reset();
    wr(2'd0, 32'h0000_1234);
    @(negedge clk) check("R7 staged", time_o, 64'h0);
    wr(2'd1, 32'h0000_00AB);
    @(negedge clk) check("R7 load", time_o, 64'h0000_00AB_0000_1234);
    // R7 divider restart
    wr(2'd2, {8'd4, 24'd1});
    repeat (7) @(posedge clk);
    wr(2'd0, 32'h10);
    wr(2'd1, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) check("R7 restart no tick", time_o, 64'h10);
    @(posedge clk);
    @(negedge clk) check("R7 restart tick", time_o, 64'h11);

    // R5 boundary adoption
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd2, {8'd1, 24'h000100});
    repeat (2) @(posedge clk);
    @(negedge clk) check("R5 undisturbed", time_o, 64'h0);
    @(posedge clk);
    @(negedge clk) check("R5 old addend", time_o, 64'h1);
    repeat (2) @(posedge clk);
    @(negedge clk) check("R5 new word", time_o, 64'h201);
    rd(2'd2, d); check("R2 pending readback", {32'h0, d}, 64'h0100_0100);

    // R6 coherent read
    do_reset();
    wr(2'd2, {8'd1, 24'h000010});
    wr(2'd0, 32'hFFFF_FFF0);
    wr(2'd1, 32'h0000_0001);
    rd(2'd0, d); check("R6 low", {32'h0, d}, 64'hFFFF_FFF0);
    @(negedge clk) hi_now = time_o[63:32];
    check("R6 counter moved", {32'h0, hi_now}, 64'h2);
    rd(2'd1, d); check("R6 shadow", {32'h0, d}, 64'h1);

    // R8 wrap flag
    do_reset();
    wr(2'd2, {8'd1, 24'h000010});
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd1, 32'hFFFF_FFFF);
    @(negedge clk) check("R8 before wrap", {63'h0, wrap_o}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    check("R8 set", {63'h0, wrap_o}, 64'h1);
    check("R8 wrapped time", time_o, 64'h8);
    rd(2'd3, d); check("R8 read", {32'h0, d}, 64'h1);
    wr(2'd3, 32'h0);
    @(negedge clk) check("R8 write 0 ignored", {63'h0, wrap_o}, 64'h1);
    wr(2'd3, 32'h1);
    @(negedge clk) check("R8 clear", {63'h0, wrap_o}, 64'h0);
    rd(2'd3, d); check("R8 read cleared", {32'h0, d}, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule